// File: doc/BRIEF.md
# Stack Pointer Bounds Monitor

This block sits beside a CPU core and compares every valid stack pointer value the core reports against a programmable lower limit and upper limit. A value strictly below the lower limit is an underflow event, and a value strictly above the upper limit is an overflow event. Both comparisons are unsigned over 32 bits. Each event kind has its own detection enable. Detected events land in a sticky raw status register. The program counter that goes with the first event is latched, so software can find the offending code.

Software sets up the limits, the enables and the interrupt mask over a simple 32-bit register bus. The bus has a write strobe, an address and write data, and it returns read data combinationally. A single level interrupt line is driven from a flop. It goes high when any raw status bit is set together with its interrupt enable. Software clears status by writing ones to a write-trigger register. A clock gate bit can freeze detection, and a read-only version word identifies the block.

Top module: `sp_guard_top`

## Requirements
- R1: After reset, the lower limit (offset 0x10) reads 0x00000000 and the upper limit (offset 0x14) reads 0xFFFFFFFF. The detection enable (0x00), raw status (0x04), interrupt enable (0x08) and captured PC (0x18) read 0. The gate register (0x30) reads 1.
- R2: Bit 0 of the detection enable, raw status, interrupt enable and clear registers is the underflow check. With bit 0 of 0x00 set, a valid stack pointer that is unsigned-less than the lower limit sets raw status bit 0 at the next clock edge.
- R3: Bit 1 of those same four registers is the overflow check. With bit 1 of 0x00 set, a valid stack pointer that is unsigned-greater than the upper limit sets raw status bit 1 at the next clock edge. This includes values of 0x80000000 and above.
- R4: No raw bit sets when its detection enable is 0, when the valid strobe is low, or when the stack pointer equals a limit.
- R5: Raw status bits are sticky. Writing 1 to a bit of the clear register (0x0C) clears the matching raw bit. A set condition in the same cycle as the clear wins. The clear register always reads 0.
- R6: The captured PC register (0x18) loads the core's program counter only when the raw status goes from all-zero to non-zero. It holds its value while any raw bit stays set. It reloads on the next event after all raw bits have been cleared.
- R7: The interrupt output is a flop that equals, one cycle later, the OR over both checks of (raw status AND interrupt enable).
- R8: While bit 0 of the gate register (0x30) is 0, no raw bit sets. Clearing through 0x0C still works.
- R9: Offset 0x1FC reads the 28-bit version value 34627616 in its low bits. Writes to it have no effect.
- R10: Offsets that are not mapped read as 0. Writes to them change no register.
- R11: Enable, interrupt-enable, limit and gate registers read back the value last written. The enable and interrupt-enable registers are 2 bits wide, and the gate register is 1 bit wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| spValue | input | 32 | Live stack pointer from the core |
| spValid | input | 1 | Stack pointer valid strobe |
| pcValue | input | 32 | Current program counter from the core |
| irqOut | output | 1 | Level interrupt, registered |

## Verification
The stack pointer is driven to values just inside each limit, exactly on each limit and one past each limit. This separates a strict compare from an inclusive one. A value with the top bit set is used to separate an unsigned compare from a signed one. The same out-of-range values are also driven with the valid strobe low, with detection disabled and with the gate off, which shows whether each of those qualifiers is honoured. A second event while status is already set, and an event in the same cycle as a clear, separate first-event PC capture and set-over-clear priority from a plain overwrite. Every clock, a behavioural model is compared with the interrupt line.

// File: rtl/sp_guard_pkg.sv
package sp_guard_pkg;
  localparam int NUM_CHK   = 2;
  localparam int CHK_UNDER = 0;
  localparam int CHK_OVER  = 1;

  localparam int OFS_DET  = 'h000;
  localparam int OFS_RAW  = 'h004;
  localparam int OFS_IEN  = 'h008;
  localparam int OFS_CLR  = 'h00C;
  localparam int OFS_LOW  = 'h010;
  localparam int OFS_HIGH = 'h014;
  localparam int OFS_PC   = 'h018;
  localparam int OFS_GATE = 'h030;
  localparam int OFS_VER  = 'h1FC;

  typedef struct packed {
    logic [NUM_CHK-1:0] detEn;
    logic [NUM_CHK-1:0] irqEn;
    logic [NUM_CHK-1:0] clrMask;
    logic               gateOn;
  } guardCtl_t;
endpackage

// File: rtl/sp_guard_regs.sv
module sp_guard_regs
  import sp_guard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int XLEN      = 32,
  parameter int VERSION_W = 28,
  parameter int VERSION   = 34627616
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [XLEN-1:0]     regWdata,
  output logic [XLEN-1:0]     regRdata,
  input  logic [NUM_CHK-1:0]  rawStat,
  input  logic [XLEN-1:0]     capPc,
  output guardCtl_t           ctl,
  output logic [XLEN-1:0]     lowBound,
  output logic [XLEN-1:0]     highBound
);
  localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(OFS_DET);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFS_LOW);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFS_HIGH);
  localparam logic [ADDR_W-1:0] A_PC   = ADDR_W'(OFS_PC);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(OFS_GATE);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFS_VER);
  localparam logic [XLEN-1:0]   VER_WORD =
    XLEN'(VERSION) & ((XLEN'(1) << VERSION_W) - XLEN'(1));

  logic [NUM_CHK-1:0] detReg;
  logic [NUM_CHK-1:0] ienReg;
  logic               gateReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      detReg    <= '0;
      ienReg    <= '0;
      gateReg   <= 1'b1;
      lowBound  <= '0;
      highBound <= '1;
    end else if (regWrEn) begin
      case (regAddr)
        A_DET:   detReg    <= regWdata[NUM_CHK-1:0];
        A_IEN:   ienReg    <= regWdata[NUM_CHK-1:0];
        A_GATE:  gateReg   <= regWdata[0];
        A_LOW:   lowBound  <= regWdata;
        A_HIGH:  highBound <= regWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.detEn   = detReg;
    ctl.irqEn   = ienReg;
    ctl.gateOn  = gateReg;
    ctl.clrMask = (regWrEn && regAddr == A_CLR) ? regWdata[NUM_CHK-1:0] : '0;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_DET:   regRdata = XLEN'(detReg);
      A_RAW:   regRdata = XLEN'(rawStat);
      A_IEN:   regRdata = XLEN'(ienReg);
      A_LOW:   regRdata = lowBound;
      A_HIGH:  regRdata = highBound;
      A_PC:    regRdata = capPc;
      A_GATE:  regRdata = XLEN'(gateReg);
      A_VER:   regRdata = VER_WORD;
      default: regRdata = '0;
    endcase
  end

  // a_r5_clear_strobe_pulse: the clear strobe never outlives the write strobe
  a_r5_clear_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !regWrEn |-> (ctl.clrMask == '0));
endmodule

// File: rtl/sp_guard_core.sv
module sp_guard_core
  import sp_guard_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  guardCtl_t          ctl,
  input  logic [XLEN-1:0]    lowBound,
  input  logic [XLEN-1:0]    highBound,
  input  logic [XLEN-1:0]    spValue,
  input  logic               spValid,
  input  logic [XLEN-1:0]    pcValue,
  output logic [NUM_CHK-1:0] rawStat,
  output logic [XLEN-1:0]    capPc,
  output logic               irqOut
);
  logic [NUM_CHK-1:0] hit;
  logic [NUM_CHK-1:0] setMask;

  for (genvar i = 0; i < NUM_CHK; i++) begin : g_chk
    if (i == CHK_UNDER) begin : g_under
      assign hit[i] = spValue < lowBound;
    end else begin : g_over
      assign hit[i] = spValue > highBound;
    end
  end

  assign setMask = (ctl.gateOn && spValid) ? (hit & ctl.detEn) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rawStat <= '0;
      capPc   <= '0;
      irqOut  <= 1'b0;
    end else begin
      rawStat <= (rawStat & ~ctl.clrMask) | setMask;
      if (rawStat == '0 && setMask != '0) capPc <= pcValue;
      irqOut  <= |(rawStat & ctl.irqEn);
    end
  end

  a_r2_under_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.gateOn && spValid && ctl.detEn[CHK_UNDER] && spValue < lowBound)
      |=> rawStat[CHK_UNDER]);
  a_r4_invalid_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    !spValid |=> ((rawStat & ~$past(rawStat)) == '0));
  a_r5_sticky_over: assert property (@(posedge clk) disable iff (!rst_n)
    (rawStat[CHK_OVER] && !ctl.clrMask[CHK_OVER]) |=> rawStat[CHK_OVER]);
  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rawStat != '0) |=> $stable(capPc));
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rawStat & ctl.irqEn)) |=> irqOut);
  a_r8_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.gateOn |=> ((rawStat & ~$past(rawStat)) == '0));
endmodule

// File: rtl/sp_guard_top.sv
module sp_guard_top
  import sp_guard_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int XLEN      = 32,
  parameter int VERSION_W = 28,
  parameter int VERSION   = 34627616
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [XLEN-1:0]   regWdata,
  output logic [XLEN-1:0]   regRdata,
  input  logic [XLEN-1:0]   spValue,
  input  logic              spValid,
  input  logic [XLEN-1:0]   pcValue,
  output logic              irqOut
);
  guardCtl_t          ctl;
  logic [XLEN-1:0]    lowBound;
  logic [XLEN-1:0]    highBound;
  logic [NUM_CHK-1:0] rawStat;
  logic [XLEN-1:0]    capPc;

  sp_guard_regs #(
    .ADDR_W(ADDR_W), .XLEN(XLEN), .VERSION_W(VERSION_W), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rawStat(rawStat),
    .capPc(capPc), .ctl(ctl), .lowBound(lowBound), .highBound(highBound)
  );

  sp_guard_core #(.XLEN(XLEN)) u_core (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .lowBound(lowBound),
    .highBound(highBound), .spValue(spValue), .spValid(spValid),
    .pcValue(pcValue), .rawStat(rawStat), .capPc(capPc), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_sp_guard_top.sv
module sim_sp_guard_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] spValue = '0;
  logic        spValid = 1'b0;
  logic [31:0] pcValue = '0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [1:0]  mDet, mIen, mRaw;
  logic [31:0] mLow, mHigh, mPc;
  logic        mGate, mIrq;

  always #5 clk = ~clk;

  sp_guard_top u0 (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .spValue(spValue),
    .spValid(spValid), .pcValue(pcValue), .irqOut(irqOut)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mDet <= 0; mIen <= 0; mRaw <= 0; mLow <= 0; mHigh <= 32'hFFFF_FFFF;
      mPc <= 0; mGate <= 1; mIrq <= 0;
    end else begin
      logic [1:0] s, c;
      s = 2'b00;
      if (mGate && spValid) begin
        if (mDet[0] && (spValue < mLow))  s[0] = 1'b1;
        if (mDet[1] && (spValue > mHigh)) s[1] = 1'b1;
      end
      c = (regWrEn && regAddr == 12'h00C) ? regWdata[1:0] : 2'b00;
      mRaw <= (mRaw & ~c) | s;
      if (mRaw == 0 && s != 0) mPc <= pcValue;
      mIrq <= (mRaw & mIen) != 0;
      if (regWrEn) begin
        if (regAddr == 12'h000) mDet  <= regWdata[1:0];
        if (regAddr == 12'h008) mIen  <= regWdata[1:0];
        if (regAddr == 12'h010) mLow  <= regWdata;
        if (regAddr == 12'h014) mHigh <= regWdata;
        if (regAddr == 12'h030) mGate <= regWdata[0];
      end
    end
  end

  function automatic logic [31:0] mRead(input logic [11:0] a);
    case (a)
      12'h000: return {30'd0, mDet};
      12'h004: return {30'd0, mRaw};
      12'h008: return {30'd0, mIen};
      12'h010: return mLow;
      12'h014: return mHigh;
      12'h018: return mPc;
      12'h030: return {31'd0, mGate};
      12'h1FC: return 32'd34627616;
      default: return 32'd0;
    endcase
  endfunction

  // R7: interrupt line compared with the model every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irqOut !== mIrq) begin
        failures++;
        $display("FAIL R7 irqOut actual=%0b expected=%0b at %0t", irqOut, mIrq, $time);
      end
    end
  end

  task automatic rdCheck(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    checks++;
    if (regRdata !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, regRdata, exp);
    end
    if (exp !== mRead(a)) begin
      failures++;
      $display("FAIL %s model addr=%h actual=%h expected=%h", tag, a, mRead(a), exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 0; regWdata = 0;
  endtask

  task automatic spPulse(input logic [31:0] sp, input logic [31:0] pc, input logic v);
    @(negedge clk);
    spValue = sp; pcValue = pc; spValid = v;
    @(negedge clk);
    spValid = 0;
  endtask

  task automatic spWithClear(input logic [31:0] sp, input logic [31:0] pc, input logic [1:0] clr);
    @(negedge clk);
    spValue = sp; pcValue = pc; spValid = 1;
    regWrEn = 1; regAddr = 12'h00C; regWdata = {30'd0, clr};
    @(negedge clk);
    spValid = 0; regWrEn = 0; regWdata = 0;
  endtask

  task automatic irqCheck(input logic exp, input string tag);
    @(negedge clk);
    #1;
    checks++;
    if (irqOut !== exp) begin
      failures++;
      $display("FAIL %s irqOut actual=%0b expected=%0b", tag, irqOut, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdCheck(12'h010, 32'h0000_0000, "R1 lower");
    rdCheck(12'h014, 32'hFFFF_FFFF, "R1 upper");
    rdCheck(12'h000, 32'h0, "R1 det");
    rdCheck(12'h004, 32'h0, "R1 raw");
    rdCheck(12'h008, 32'h0, "R1 ien");
    rdCheck(12'h018, 32'h0, "R1 pc");
    rdCheck(12'h030, 32'h1, "R1 gate");
    rdCheck(12'h1FC, 32'd34627616, "R9 version");
    // R4: detection disabled
    wr(12'h010, 32'h0000_1000);
    spPulse(32'h0, 32'h10, 1);
    rdCheck(12'h004, 32'h0, "R4 disabled");
    // R11 configuration readback
    wr(12'h014, 32'h0000_2000);
    wr(12'h000, 32'h3);
    wr(12'h008, 32'h3);
    rdCheck(12'h000, 32'h3, "R11 det");
    rdCheck(12'h008, 32'h3, "R11 ien");
    rdCheck(12'h010, 32'h1000, "R11 lower");
    rdCheck(12'h014, 32'h2000, "R11 upper");
    // R4: equality and invalid strobe
    spPulse(32'h1000, 32'h20, 1);
    spPulse(32'h2000, 32'h24, 1);
    spPulse(32'h0FFF, 32'h28, 0);
    spPulse(32'h2001, 32'h2C, 0);
    rdCheck(12'h004, 32'h0, "R4 equal/invalid");
    // R2 underflow, R6 capture
    spPulse(32'h0FFF, 32'hAAAA, 1);
    rdCheck(12'h004, 32'h1, "R2 underflow");
    rdCheck(12'h018, 32'hAAAA, "R6 capture");
    irqCheck(1, "R7 raised");
    // R3 overflow, R6 hold
    spPulse(32'h2001, 32'hBBBB, 1);
    rdCheck(12'h004, 32'h3, "R3 overflow");
    rdCheck(12'h018, 32'hAAAA, "R6 hold");
    // R5 clear one bit, clear reg reads zero
    wr(12'h00C, 32'h1);
    rdCheck(12'h004, 32'h2, "R5 clear bit0");
    rdCheck(12'h00C, 32'h0, "R5 clear reads 0");
    // R7 masking
    wr(12'h008, 32'h1);
    irqCheck(0, "R7 masked");
    // R5 set wins over clear
    spWithClear(32'h3000, 32'hCCCC, 2'b10);
    rdCheck(12'h004, 32'h2, "R5 set wins");
    rdCheck(12'h018, 32'hAAAA, "R6 hold on clear+set");
    wr(12'h00C, 32'h3);
    rdCheck(12'h004, 32'h0, "R5 clear all");
    // R3 unsigned compare, R6 reload
    spPulse(32'h8000_0000, 32'hDDDD, 1);
    rdCheck(12'h004, 32'h2, "R3 unsigned");
    rdCheck(12'h018, 32'hDDDD, "R6 reload");
    wr(12'h00C, 32'h3);
    // R8 gate freeze
    wr(12'h030, 32'h0);
    rdCheck(12'h030, 32'h0, "R11 gate");
    spPulse(32'h0, 32'hEEEE, 1);
    spPulse(32'hFFFF_0000, 32'hEEEE, 1);
    rdCheck(12'h004, 32'h0, "R8 frozen");
    wr(12'h030, 32'h1);
    spPulse(32'h0, 32'h1234, 1);
    rdCheck(12'h004, 32'h1, "R8 resumed");
    wr(12'h030, 32'h0);
    wr(12'h00C, 32'h1);
    rdCheck(12'h004, 32'h0, "R8 clear while gated");
    wr(12'h030, 32'h1);
    // R9 version write ignored
    wr(12'h1FC, 32'h0);
    rdCheck(12'h1FC, 32'd34627616, "R9 write ignored");
    // R10 unmapped
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h011, 32'h5555_5555);
    rdCheck(12'h040, 32'h0, "R10 unmapped read");
    rdCheck(12'h011, 32'h0, "R10 unaligned read");
    rdCheck(12'h010, 32'h1000, "R10 lower intact");
    rdCheck(12'h000, 32'h3, "R10 det intact");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule